// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple synchronous host port and a 64K x 16 asynchronous DRAM whose address pins are shared between row and column. A host request carries a 16-bit word address, a write flag, write data and two byte enables. The controller turns it into the RAS, CAS, WE and OE sequence the memory needs. Read data comes back on a split data bus together with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row runs as a column-only page cycle, which saves the row activation and precharge. A request to another row closes the open row and opens the new one. The row is also closed when it has been open for too long, or when an external refresh sequencer raises its grant input.

Every timing minimum is given in picoseconds and turned into a whole number of controller clocks, rounded up, for the chosen clock period.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, RAS, both CAS strobes, WE and OE are high (inactive), the data bus driver is off, rd_valid is low, and req_ready is high while ref_grant is low.
- R2: The row is the upper 8 bits of req_addr and is presented on dram_addr when RAS falls. The column is the lower 8 bits and is presented when CAS falls. dram_addr does not change while any CAS strobe stays low.
- R3: Bit 0 of req_be and of dram_cas_n belongs to data bits 7:0, and bit 1 belongs to data bits 15:8. Only the CAS strobes of enabled lanes go low. In returned read data, every lane that is not enabled reads as zero.
- R4: A write drives WE low, OE high and the data bus from the same cycle in which CAS falls, until CAS rises. A read keeps WE high, drives OE low and leaves the data bus undriven.
- R5: Read data appears with rd_valid high for exactly one cycle. From a closed row this happens T_RCD+T_COL cycles after the accepting edge (4 at the default timing and 8 ns clock). On a page hit it happens T_COL cycles after (2).
- R6: A request to the open row gets a new column without RAS rising. Between two page accesses, CAS stays high for at least T_CP cycles.
- R7: A request to a different row raises RAS for at least T_RP cycles (4) before the new row is activated. Its read data arrives T_RP+T_RCD+T_COL cycles after acceptance (8). Every RAS high period before an activation lasts at least T_RP cycles.
- R8: CAS goes low only while RAS is low, and only after RAS has been low for at least T_RCD cycles (2).
- R9: RAS never stays low for more than RAS_MAX cycles. When the limit is near, the row is closed and a later access reopens it.
- R10: While ref_grant is high, req_ready is low, an open row is closed, and no new row is activated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 16 | Word address, row in the upper byte |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables |
| rd_data | output | 16 | Read data, lanes not enabled are zero |
| rd_valid | output | 1 | One-cycle read data strobe |
| ref_grant | input | 1 | Refresh grant; forces the row closed |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Write data to memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Read data from memory |

## Verification
The bench tests back-to-back hits to one row, a miss straight after a hit, and a read of an address that differs from a written one only in its row bits. A design with a bad row compare or a swapped address split would return the wrong word there, or reopen RAS on a hit. Byte writes to both halves of one word, followed by byte reads, expose a design that asserts both CAS strobes, or that returns the unselected lane unmasked (the memory model puts junk there). A long run of hits with a small RAS limit shows whether the row is closed in time and reopened. Holding a request through a refresh grant shows whether a design leaks an activation while the grant is high.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CPRE,
    ST_OPEN,
    ST_PRE
  } fpm_state_e;

  // duration in ps to whole clock cycles, rounded up, at least one
  function automatic int fpm_cycles(input int dur_ps, input int clk_ps);
    int c;
    c = (dur_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int fpm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_step_timer.sv
module fpm_step_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/fpm_ras_tracker.sv
module fpm_ras_tracker #(
  parameter int ROW_W   = 8,
  parameter int RAS_MAX = 12500,
  parameter int T_RP    = 4,
  parameter int T_TAIL  = 4,
  parameter int LO_W    = $clog2(RAS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             row_load,
  input  logic [ROW_W-1:0] row_in,
  output logic [ROW_W-1:0] open_row,
  output logic [LO_W-1:0]  lo_cnt,
  output logic             expired
);

  localparam int HI_W  = $clog2(T_RP + 1);
  localparam int LIMIT = RAS_MAX - T_TAIL;

  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt   <= '0;
      hi_cnt   <= HI_W'(T_RP);
      open_row <= '0;
    end else begin
      if (ras_n) begin
        lo_cnt <= '0;
        if (hi_cnt != HI_W'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      end
      if (row_load) open_row <= row_in;
    end
  end

  // close in time: one more page access plus the decision cycle must fit
  assign expired = !ras_n && (lo_cnt >= LO_W'(LIMIT));

  p_ras_window_r9: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (lo_cnt < LO_W'(RAS_MAX)));

  p_precharge_r7: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $past(ras_n)) |-> ($past(hi_cnt) >= HI_W'(T_RP - 1)));

endmodule

// File: rtl/fpm_lane_io.sv
module fpm_lane_io #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int LW = DATA_W / LANES;

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= capture;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_data[g*LW +: LW] <= '0;
      end else if (capture) begin
        rd_data[g*LW +: LW] <= be[g] ? dq_in[g*LW +: LW] : '0;
      end
    end
  end

  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ROW_W       = 8,
  parameter int DATA_W      = 16,
  parameter int LANES       = 2,
  parameter int CLK_PS      = 8000,
  parameter int TRCD_PS     = 13000,
  parameter int TAA_PS      = 15000,
  parameter int TPC_PS      = 18000,
  parameter int TCP_PS      = 5500,
  parameter int TRP_PS      = 25000,
  parameter int TRAS_MAX_PS = 100000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              ref_grant,
  output logic [fpm_max(ROW_W, ADDR_W - ROW_W)-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic [LANES-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  localparam int COL_W   = ADDR_W - ROW_W;
  localparam int MA_W    = fpm_max(ROW_W, COL_W);
  localparam int T_RCD   = fpm_cycles(TRCD_PS, CLK_PS);
  localparam int T_CP    = fpm_cycles(TCP_PS, CLK_PS);
  localparam int T_COL   = fpm_max(fpm_cycles(TAA_PS, CLK_PS),
                                   fpm_cycles(TPC_PS, CLK_PS) - T_CP);
  localparam int T_RP    = fpm_cycles(TRP_PS, CLK_PS);
  localparam int RAS_MAX = fpm_cycles(TRAS_MAX_PS, CLK_PS);
  localparam int T_TAIL  = T_COL + T_CP + 1;
  localparam int T_BIG   = fpm_max(fpm_max(T_RCD, T_COL), fpm_max(T_CP, T_RP));
  localparam int TW      = $clog2(T_BIG + 1);
  localparam int LO_W    = $clog2(RAS_MAX + 1);

  fpm_state_e state, nstate;

  logic [ADDR_W-1:0] cur_addr;
  logic              cur_we;
  logic [DATA_W-1:0] cur_wdata;
  logic [LANES-1:0]  cur_be;
  logic              pend, n_pend;

  logic              take, cap, tload, tdone, hit, expired;
  logic [TW-1:0]     tval;
  logic [ROW_W-1:0]  open_row;
  logic [LO_W-1:0]   lo_cnt;

  logic [ADDR_W-1:0] nx_addr;
  logic              nx_we;
  logic [DATA_W-1:0] nx_wdata;
  logic [LANES-1:0]  nx_be;
  logic              in_col;

  assign req_ready = !ref_grant &&
                     ((state == ST_IDLE) || ((state == ST_OPEN) && !expired));
  assign hit = (req_addr[ADDR_W-1:COL_W] == open_row);

  // sequencing
  always_comb begin
    nstate = state;
    tload  = 1'b0;
    tval   = '0;
    take   = 1'b0;
    cap    = 1'b0;
    n_pend = pend;
    case (state)
      ST_IDLE: begin
        if (req_valid && req_ready) begin
          take   = 1'b1;
          nstate = ST_ROW;
          tload  = 1'b1;
          tval   = TW'(T_RCD - 1);
        end
      end
      ST_ROW: begin
        if (tdone) begin
          nstate = ST_COL;
          tload  = 1'b1;
          tval   = TW'(T_COL - 1);
        end
      end
      ST_COL: begin
        if (tdone) begin
          nstate = ST_CPRE;
          tload  = 1'b1;
          tval   = TW'(T_CP - 1);
          cap    = !cur_we;
        end
      end
      ST_CPRE: begin
        if (tdone) nstate = ST_OPEN;
      end
      ST_OPEN: begin
        if (ref_grant || expired) begin
          nstate = ST_PRE;
          tload  = 1'b1;
          tval   = TW'(T_RP - 1);
        end else if (req_valid) begin
          take  = 1'b1;
          tload = 1'b1;
          if (hit) begin
            nstate = ST_COL;
            tval   = TW'(T_COL - 1);
          end else begin
            nstate = ST_PRE;
            tval   = TW'(T_RP - 1);
            n_pend = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (tdone && !ref_grant) begin
          if (pend) begin
            nstate = ST_ROW;
            tload  = 1'b1;
            tval   = TW'(T_RCD - 1);
            n_pend = 1'b0;
          end else begin
            nstate = ST_IDLE;
          end
        end
      end
      default: nstate = ST_IDLE;
    endcase
  end

  assign nx_addr  = take ? req_addr  : cur_addr;
  assign nx_we    = take ? req_we    : cur_we;
  assign nx_wdata = take ? req_wdata : cur_wdata;
  assign nx_be    = take ? req_be    : cur_be;
  assign in_col   = (nstate == ST_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pend        <= 1'b0;
      cur_addr    <= '0;
      cur_we      <= 1'b0;
      cur_wdata   <= '0;
      cur_be      <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= '1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      state <= nstate;
      pend  <= n_pend;
      if (take) begin
        cur_addr  <= req_addr;
        cur_we    <= req_we;
        cur_wdata <= req_wdata;
        cur_be    <= req_be;
      end
      dram_ras_n <= !((nstate == ST_ROW) || (nstate == ST_COL) ||
                      (nstate == ST_CPRE) || (nstate == ST_OPEN));
      if (nstate == ST_ROW)
        dram_addr <= MA_W'(nx_addr[ADDR_W-1:COL_W]);
      else if (in_col)
        dram_addr <= MA_W'(nx_addr[COL_W-1:0]);
      dram_cas_n <= in_col ? ~nx_be : '1;
      dram_we_n  <= !(in_col && nx_we);
      dram_oe_n  <= !(in_col && !nx_we);
      dram_dq_oe <= in_col && nx_we;
      if (in_col) dram_dq_out <= nx_wdata;
    end
  end

  fpm_step_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tload),
    .load_val (tval),
    .done     (tdone)
  );

  fpm_ras_tracker #(
    .ROW_W   (ROW_W),
    .RAS_MAX (RAS_MAX),
    .T_RP    (T_RP),
    .T_TAIL  (T_TAIL),
    .LO_W    (LO_W)
  ) u_ras (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (dram_ras_n),
    .row_load ((nstate == ST_ROW) && (state != ST_ROW)),
    .row_in   (nx_addr[ADDR_W-1:COL_W]),
    .open_row (open_row),
    .lo_cnt   (lo_cnt),
    .expired  (expired)
  );

  fpm_lane_io #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .capture  (cap),
    .be       (cur_be),
    .dq_in    (dram_dq_in),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  p_cas_in_row_r8: assert property (@(posedge clk) disable iff (rst)
    (dram_cas_n != '1) |-> !dram_ras_n);

  p_rcd_r8: assert property (@(posedge clk) disable iff (rst)
    ((dram_cas_n != '1) && ($past(dram_cas_n) == '1)) |-> (lo_cnt >= LO_W'(T_RCD)));

  p_write_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> (dram_oe_n && dram_dq_oe && (dram_cas_n != '1)));

  p_col_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ((dram_cas_n != '1) && ($past(dram_cas_n) != '1)) |-> $stable(dram_addr));

  p_grant_block_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(ref_grant) && $past(dram_ras_n)) |-> dram_ras_n);

endmodule

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb;

  localparam int B_RCD = 2;
  localparam int B_COL = 2;
  localparam int B_CP  = 1;
  localparam int B_RP  = 4;
  localparam int B_RAS = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        ref_grant = 1'b0;
  logic [7:0]  dram_addr;
  logic        dram_ras_n;
  logic [1:0]  dram_cas_n;
  logic        dram_we_n;
  logic        dram_oe_n;
  logic [15:0] dram_dq_out;
  logic        dram_dq_oe;
  logic [15:0] dq_drv = '0;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(.TRAS_MAX_PS(320000)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_be(req_be),
    .rd_data(rd_data), .rd_valid(rd_valid), .ref_grant(ref_grant),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_drv)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done_flag = 0;

  typedef struct { logic [15:0] d; int lat; int acc; string tag; } exp_t;
  exp_t exq[$];

  logic [15:0] dmem [int];
  logic [15:0] shadow [int];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      report();
    end
  end

  // memory model and pin monitor
  logic       p_ras = 1'b1;
  logic [1:0] p_cas = 2'b11;
  logic [7:0] p_addr = '0;
  logic [7:0] row_l = '0;
  int lo_run = 0, hi_run = 100, cas_hi = 100, ras_falls = 0;
  bit p_rv = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (dram_ras_n && !p_ras)
        chk(lo_run <= B_RAS, "R9", "RAS low run", lo_run, B_RAS);
      if (!dram_ras_n && p_ras) begin
        chk(hi_run >= B_RP, "R7", "RAS high before activation", hi_run, B_RP);
        row_l = dram_addr;
        ras_falls++;
      end
      if (dram_ras_n) begin hi_run++; lo_run = 0; end
      else begin hi_run = 0; lo_run++; end

      if ((p_cas == 2'b11) && (dram_cas_n != 2'b11)) begin
        chk(!dram_ras_n && lo_run >= B_RCD + 1, "R8", "RAS-to-CAS cycles", lo_run, B_RCD + 1);
        chk(cas_hi >= B_CP, "R6", "CAS high time", cas_hi, B_CP);
        if (!dram_we_n) begin
          chk(dram_dq_oe && dram_oe_n, "R4", "write strobes oe/dq_oe", {dram_oe_n, dram_dq_oe}, 2'b11);
          for (int i = 0; i < 2; i++) begin
            if (!dram_cas_n[i]) begin
              int a;
              logic [15:0] w;
              a = int'({row_l, dram_addr});
              w = dmem.exists(a) ? dmem[a] : 16'h0;
              w[i*8 +: 8] = dram_dq_out[i*8 +: 8];
              dmem[a] = w;
            end
          end
        end else begin
          chk(!dram_oe_n && !dram_dq_oe, "R4", "read strobes oe_n/dq_oe", {dram_oe_n, dram_dq_oe}, 2'b00);
        end
      end
      if ((p_cas != 2'b11) && (dram_cas_n != 2'b11))
        chk(dram_addr == p_addr, "R2", "column held under CAS", dram_addr, p_addr);
      if (dram_cas_n != 2'b11 && !dram_we_n)
        chk(dram_dq_oe, "R4", "data driven during write CAS", dram_dq_oe, 1);
      cas_hi = (dram_cas_n == 2'b11) ? cas_hi + 1 : 0;

      for (int i = 0; i < 2; i++) begin
        int a;
        a = int'({row_l, dram_addr});
        if (!dram_cas_n[i] && dram_we_n)
          dq_drv[i*8 +: 8] = dmem.exists(a) ? dmem[a][i*8 +: 8] : 8'h00;
        else
          dq_drv[i*8 +: 8] = 8'hA5;
      end

      if (rd_valid) begin
        chk(!p_rv, "R5", "rd_valid single pulse", p_rv, 0);
        if (exq.size() == 0) begin
          chk(0, "R5", "unexpected rd_valid", 1, 0);
        end else begin
          exp_t e;
          e = exq.pop_front();
          chk(rd_data == e.d, e.tag, "read data", rd_data, e.d);
          if (e.lat >= 0)
            chk(cyc - e.acc == e.lat, e.tag, "read latency", cyc - e.acc, e.lat);
        end
      end
      p_rv   = rd_valid;
      p_cas  = dram_cas_n;
      p_ras  = dram_ras_n;
      p_addr = dram_addr;
    end
  end

  task automatic issue(input logic [15:0] a, input logic we, input logic [15:0] d,
                       input logic [1:0] be, input int lat, input string tag);
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d; req_be = be;
    #1 ok = req_ready;
    while (!ok) begin
      @(negedge clk);
      #1 ok = req_ready;
    end
    @(posedge clk);
    #1;
    if (we) begin
      logic [15:0] w;
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end else begin
      exp_t e;
      logic [15:0] w;
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
      e.d   = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
      e.lat = lat;
      e.acc = cyc;
      e.tag = tag;
      exq.push_back(e);
    end
  endtask

  task automatic idle_for(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int f0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dram_ras_n == 1'b1, "R1", "ras_n", dram_ras_n, 1);
    chk(dram_cas_n == 2'b11, "R1", "cas_n", dram_cas_n, 3);
    chk(dram_we_n && dram_oe_n, "R1", "we_n/oe_n", {dram_we_n, dram_oe_n}, 3);
    chk(!dram_dq_oe, "R1", "dq_oe", dram_dq_oe, 0);
    chk(!rd_valid, "R1", "rd_valid", rd_valid, 0);
    chk(req_ready, "R1", "req_ready", req_ready, 1);

    // R2/R5/R6: write then page-hit read
    issue(16'h1234, 1'b1, 16'hBEEF, 2'b11, -1, "R2");
    issue(16'h1234, 1'b0, 16'h0, 2'b11, B_COL, "R6");
    // R3 byte lanes within the same row
    issue(16'h1256, 1'b1, 16'h1111, 2'b01, -1, "R3");
    issue(16'h1256, 1'b1, 16'h2200, 2'b10, -1, "R3");
    issue(16'h1256, 1'b0, 16'h0, 2'b11, B_COL, "R3");
    issue(16'h1256, 1'b0, 16'h0, 2'b01, B_COL, "R3");
    issue(16'h1256, 1'b0, 16'h0, 2'b10, B_COL, "R3");
    idle_for(8);
    chk(ras_falls == 1, "R6", "activations for one row", ras_falls, 1);

    // R7 misses; R2 row bits separate words
    issue(16'h3456, 1'b0, 16'h0, 2'b11, B_RP + B_RCD + B_COL, "R7");
    issue(16'h34AB, 1'b1, 16'hCAFE, 2'b11, -1, "R7");
    issue(16'h34AB, 1'b0, 16'h0, 2'b11, B_COL, "R7");
    issue(16'h1334, 1'b0, 16'h0, 2'b11, B_RP + B_RCD + B_COL, "R2");
    issue(16'h1234, 1'b0, 16'h0, 2'b11, B_RP + B_RCD + B_COL, "R2");
    idle_for(8);
    chk(ras_falls == 4, "R7", "activations after misses", ras_falls, 4);

    // R10 refresh grant closes the row and blocks activation
    ref_grant = 1'b1;
    repeat (10) @(negedge clk);
    chk(dram_ras_n, "R10", "row closed under grant", dram_ras_n, 1);
    chk(!req_ready, "R10", "ready low under grant", req_ready, 0);
    f0 = ras_falls;
    req_valid = 1'b1; req_addr = 16'h1234; req_we = 1'b0; req_be = 2'b11;
    repeat (20) @(negedge clk);
    chk(ras_falls == f0, "R10", "no activation under grant", ras_falls, f0);
    chk(exq.size() == 0 && !rd_valid, "R10", "no read issued under grant", exq.size(), 0);
    req_valid = 1'b0;
    ref_grant = 1'b0;
    repeat (2) @(negedge clk);
    issue(16'h1234, 1'b0, 16'h0, 2'b11, B_RCD + B_COL, "R5");
    idle_for(6);

    // R9 long run of hits must be cut by the RAS limit
    f0 = ras_falls;
    for (int k = 0; k < 8; k++)
      issue({8'h20, 8'(k * 3)}, 1'b1, 16'(16'h0F00 + k), 2'b11, -1, "R9");
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 8; k++)
        issue({8'h20, 8'(k * 3)}, 1'b0, 16'h0, 2'b11, -1, "R9");
    idle_for(10);
    chk(ras_falls - f0 >= 3, "R9", "row reopened after limit", ras_falls - f0, 3);
    chk(exq.size() == 0, "R5", "all reads returned", exq.size(), 0);
    report();
  end

endmodule